// File: doc/BRIEF.md
# Cascaded Serial-Clock Phase Tick Generator

This block produces the phase timing for a two-wire bus master. From the system clock it emits a single-cycle tick once per half period of the serial clock, and the byte engine toggles its clock line on each tick. Each high and low phase therefore lasts the same number of system cycles, so the duty cycle is 50 percent.

The half period is the product of four counter stages. A base counter runs for (thp+1) system cycles. A power-of-two prescaler divides by 2^N. A divider divides by (M+1). A fixed stage divides by ten. The full serial-clock period is therefore 2*(thp+1)*2^N*(M+1)*10 system cycles. Software writes thp through one strobe and a packed divider byte through another. Choosing good values is left to software.

A small controller has three states. IDLE holds the chain cleared. RELOAD is a one-cycle clear that follows any write or a resume. COUNT advances the chain.
- IDLE goes to RELOAD when the engine is busy and not holding.
- RELOAD goes to COUNT when the engine is running, and back to IDLE otherwise.
- COUNT goes to RELOAD on any setting write, and to IDLE when the engine stops or holds.
- A write sends IDLE or RELOAD to RELOAD.

Every path into COUNT passes through RELOAD, so the first phase after a change is always a full phase.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset the settings are thp=24, M=2, N=0. With the engine running, ticks are then spaced 750 cycles apart.
- R2: While running with no writes, consecutive ticks are exactly H=(thp+1)*2^N*(M+1)*10 cycles apart.
- R3: The divider byte carries M in bits 6:3 and N in bits 2:0. A thp write leaves M and N unchanged, and a divider write leaves thp unchanged.
- R4: A thp value below 5 is stored as 5.
- R5: Every tick is high for exactly one cycle.
- R6: A write accepted at clock edge E restarts all stages. The next tick rises at edge E+H+1 under the new settings, so no phase is ever shortened.
- R7: No tick is produced while busy is low or hold is high. When the engine resumes, with busy and not hold first sampled at edge E, the first tick rises at edge E+H+1.
- R8: A write whose edge coincides with a chain wrap suppresses that tick. The next tick follows R6.
- R9: The tick is low during reset and stays low after reset while the engine is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_wr | input | 1 | Strobe: load hp_value into thp |
| hp_value | input | 8 | Half-period base count |
| div_wr | input | 1 | Strobe: load div_value into M and N |
| div_value | input | 7 | M in bits 6:3, N in bits 2:0 |
| eng_busy | input | 1 | Byte engine is active |
| eng_hold | input | 1 | Byte engine is stalling with its flag set |
| phase_tick | output | 1 | One-cycle pulse per serial-clock phase |

## Verification
Two events can land on the same clock edge: a settings write and the wrap of the full counter chain. The write must win, so no tick appears and the restart begins at once.

The bench waits for a tick and adds one period to predict the edge of the next wrap. It then drives a write to be sampled at exactly that edge. At the point where the tick would have appeared, the bench checks that the tick count has not changed. It then checks that the next tick arrives H+1 edges after the write.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_COUNT  = 2'd2
    } sclgen_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg #(
    parameter int unsigned THP_W   = 8,
    parameter int unsigned M_W     = 4,
    parameter int unsigned N_W     = 3,
    parameter int unsigned THP_MIN = 5,
    parameter int unsigned THP_RST = 24,
    parameter int unsigned M_RST   = 2,
    parameter int unsigned N_RST   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hp_wr,
    input  logic [THP_W-1:0]   hp_value,
    input  logic               div_wr,
    input  logic [M_W+N_W-1:0] div_value,
    output logic [THP_W-1:0]   thp_q,
    output logic [M_W-1:0]     m_q,
    output logic [N_W-1:0]     n_q,
    output logic               cfg_wr
);

    localparam logic [THP_W-1:0] THP_FLOOR = THP_W'(THP_MIN);

    logic [THP_W-1:0] thp_clamped;

    always_comb begin
        thp_clamped = (hp_value < THP_FLOOR) ? THP_FLOOR : hp_value;
        cfg_wr      = hp_wr | div_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thp_q <= THP_W'(THP_RST);
        end else if (hp_wr) begin
            thp_q <= thp_clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= M_W'(M_RST);
            n_q <= N_W'(N_RST);
        end else if (div_wr) begin
            m_q <= div_value[N_W +: M_W];
            n_q <= div_value[N_W-1:0];
        end
    end

    // R4: the stored base count never falls below the floor
    p_thp_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        thp_q >= THP_FLOOR);

    // R3: divider fields are taken from their packed positions
    p_div_unpack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (m_q == $past(div_value[N_W +: M_W])) && (n_q == $past(div_value[N_W-1:0])));

    // R3: a base-count write alone leaves the divider fields as they were
    p_div_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_wr && !div_wr) |=> $stable(m_q) && $stable(n_q));

endmodule

// File: rtl/sclgen_stage.sv
module sclgen_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    always_comb begin
        wrap = step && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + W'(1);
        end
    end

    // R2: a stage never runs past its modulus
    p_stage_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R6: a clear always leaves the stage at zero
    p_stage_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
    import sclgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic run,
    input  logic chain_wrap,
    output logic count_en,
    output logic chain_clear,
    output logic tick
);

    sclgen_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_wr || run) state_d = ST_RELOAD;
            end
            ST_RELOAD: begin
                if (cfg_wr)      state_d = ST_RELOAD;
                else if (run)    state_d = ST_COUNT;
                else             state_d = ST_IDLE;
            end
            ST_COUNT: begin
                if (cfg_wr)      state_d = ST_RELOAD;
                else if (!run)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        count_en    = (state_q == ST_COUNT) && run && !cfg_wr;
        chain_clear = !count_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= chain_wrap;
        end
    end

    // R5: a tick never lasts two cycles
    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R6: a write sends the controller to the reload state with no tick
    p_write_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (state_q == ST_RELOAD) && !tick);

    // R6: counting is only ever entered through reload
    p_count_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COUNT) && ($past(state_q) != ST_COUNT)) |-> ($past(state_q) == ST_RELOAD));

    // R7: a stopped engine yields no tick on the following cycle
    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int unsigned THP_W   = 8,
    parameter int unsigned M_W     = 4,
    parameter int unsigned N_W     = 3,
    parameter int unsigned THP_MIN = 5,
    parameter int unsigned THP_RST = 24,
    parameter int unsigned M_RST   = 2,
    parameter int unsigned N_RST   = 0,
    parameter int unsigned DECADE  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hp_wr,
    input  logic [THP_W-1:0]   hp_value,
    input  logic               div_wr,
    input  logic [M_W+N_W-1:0] div_value,
    input  logic               eng_busy,
    input  logic               eng_hold,
    output logic               phase_tick
);

    import sclgen_pkg::*;

    localparam int unsigned PRE_W  = (1 << N_W) - 1;
    localparam int unsigned DEC_W  = (DECADE > 1) ? $clog2(DECADE) : 1;
    localparam int unsigned STG_W  = max2(max2(THP_W, PRE_W), max2(M_W, DEC_W));
    localparam int unsigned NSTAGE = 4;

    logic [THP_W-1:0] thp_q;
    logic [M_W-1:0]   m_q;
    logic [N_W-1:0]   n_q;
    logic             cfg_wr;
    logic             run;
    logic             count_en;
    logic             chain_clear;

    logic [STG_W-1:0] stage_lim  [NSTAGE];
    logic             stage_step [NSTAGE];
    logic             stage_wrap [NSTAGE];
    logic [STG_W:0]   pre_pow;
    logic [STG_W:0]   pre_span;

    sclgen_cfg #(
        .THP_W   (THP_W),
        .M_W     (M_W),
        .N_W     (N_W),
        .THP_MIN (THP_MIN),
        .THP_RST (THP_RST),
        .M_RST   (M_RST),
        .N_RST   (N_RST)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_wr     (hp_wr),
        .hp_value  (hp_value),
        .div_wr    (div_wr),
        .div_value (div_value),
        .thp_q     (thp_q),
        .m_q       (m_q),
        .n_q       (n_q),
        .cfg_wr    (cfg_wr)
    );

    always_comb begin
        run          = eng_busy && !eng_hold;
        pre_pow      = (STG_W+1)'(1) << n_q;
        pre_span     = pre_pow - (STG_W+1)'(1);
        stage_lim[0] = STG_W'(thp_q);
        stage_lim[1] = pre_span[STG_W-1:0];
        stage_lim[2] = STG_W'(m_q);
        stage_lim[3] = STG_W'(DECADE - 1);
    end

    always_comb begin
        stage_step[0] = count_en;
        for (int k = 1; k < NSTAGE; k++) begin
            stage_step[k] = stage_wrap[k-1];
        end
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        sclgen_stage #(
            .W (STG_W)
        ) i_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (chain_clear),
            .step  (stage_step[g]),
            .limit (stage_lim[g]),
            .wrap  (stage_wrap[g])
        );
    end

    sclgen_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .run         (run),
        .chain_wrap  (stage_wrap[NSTAGE-1]),
        .count_en    (count_en),
        .chain_clear (chain_clear),
        .tick        (phase_tick)
    );

    // R7: every tick follows a cycle in which the engine was running
    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> ($past(eng_busy) && !$past(eng_hold)));

    // R8: a write on any edge, wrap or not, removes the tick of that edge
    p_write_beats_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_wr || div_wr) |=> !phase_tick);

    // R9: tick is low whenever reset is applied
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r9: assert (!phase_tick);
        end
    end

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic       clk;
    logic       rst_n;
    logic       hp_wr;
    logic [7:0] hp_value;
    logic       div_wr;
    logic [6:0] div_value;
    logic       eng_busy;
    logic       eng_hold;
    logic       phase_tick;

    int    checks;
    int    errors;
    longint cyc;
    int    ticks;
    longint last_tick;
    int    wide;
    logic  prev_tick;
    int    cur_thp;
    int    cur_m;
    int    cur_n;

    scl_rate_gen i_scl_rate_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .hp_wr      (hp_wr),
        .hp_value   (hp_value),
        .div_wr     (div_wr),
        .div_value  (div_value),
        .eng_busy   (eng_busy),
        .eng_hold   (eng_hold),
        .phase_tick (phase_tick)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        ticks = 0; wide = 0; prev_tick = 1'b0; last_tick = 0;
    end
    always @(negedge clk) begin
        if (phase_tick) begin
            ticks = ticks + 1;
            last_tick = cyc;
            if (prev_tick) wide = wide + 1;
        end
        prev_tick = phase_tick;
    end

    always @(posedge clk) begin
        if (cyc == WDOG_CYC) begin
            errors = errors + 1;
            $display("FAIL R6 watchdog actual %0d expected below %0d", cyc, WDOG_CYC);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic longint half_period(input int thp, input int m, input int n);
        int t;
        t = (thp < 5) ? 5 : thp;
        return longint'(t + 1) * longint'(1 << n) * longint'(m + 1) * 10;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // waits for a new tick; returns the cycle stamp or -1 on timeout
    task automatic wait_tick(input longint limit, output longint at);
        int n0;
        n0 = ticks;
        at = -1;
        for (longint i = 0; i < limit; i++) begin
            @(negedge clk); #1;
            if (ticks != n0) begin
                at = last_tick;
                break;
            end
        end
    endtask

    // called at negedge+1; drives one write cycle, returns drive stamp
    task automatic drive_cfg(input bit do_hp, input int thp, input bit do_div,
                             input int m, input int n, output longint c0);
        c0 = cyc;
        hp_wr     = do_hp;
        hp_value  = 8'(thp);
        div_wr    = do_div;
        div_value = {4'(m), 3'(n)};
        if (do_hp)  cur_thp = thp;
        if (do_div) begin cur_m = m; cur_n = n; end
        @(negedge clk); #1;
        hp_wr  = 1'b0;
        div_wr = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle_cycles(5);
        check("R9 tick in reset", longint'(phase_tick), 0);
        rst_n = 1'b1;
        idle_cycles(300);
        check("R9 no tick while not busy", ticks, 0);
        check("R7 busy low silent", longint'(phase_tick), 0);
    endtask

    task automatic t_default;
        longint c0, t1, t2;
        c0 = cyc;
        eng_busy = 1'b1;
        wait_tick(2000, t1);
        check("R1 first tick after resume", t1 - c0, 752);
        wait_tick(2000, t2);
        check("R1 default spacing", t2 - t1, 750);
    endtask

    task automatic t_rate(input bit do_hp, input int thp, input bit do_div,
                          input int m, input int n, input string tag);
        longint c0, t1, t2, h;
        idle_cycles(37);
        drive_cfg(do_hp, thp, do_div, m, n, c0);
        h = half_period(cur_thp, cur_m, cur_n);
        wait_tick(h * 2 + 20, t1);
        check({tag, " R6 restart latency"}, t1 - c0, h + 2);
        wait_tick(h * 2 + 20, t2);
        check({tag, " R2 spacing"}, t2 - t1, h);
    endtask

    task automatic t_hold;
        longint c0, t1, h;
        int n0;
        h = half_period(cur_thp, cur_m, cur_n);
        wait_tick(h * 2 + 20, t1);
        idle_cycles(11);
        eng_hold = 1'b1;
        n0 = ticks;
        idle_cycles(int'(h) * 3);
        check("R7 no tick while holding", ticks - n0, 0);
        c0 = cyc;
        eng_hold = 1'b0;
        wait_tick(h * 2 + 20, t1);
        check("R7 full phase after hold", t1 - c0, h + 2);
        idle_cycles(7);
        eng_busy = 1'b0;
        n0 = ticks;
        idle_cycles(int'(h) * 3);
        check("R7 no tick while not busy", ticks - n0, 0);
        c0 = cyc;
        eng_busy = 1'b1;
        wait_tick(h * 2 + 20, t1);
        check("R7 full phase after busy", t1 - c0, h + 2);
    endtask

    task automatic t_collide;
        longint c0, t1, t2, h;
        int n0;
        h = half_period(cur_thp, cur_m, cur_n);
        wait_tick(h * 2 + 20, t1);
        while (cyc != t1 + h - 1) begin
            @(negedge clk); #1;
        end
        n0 = ticks;
        drive_cfg(1'b1, cur_thp, 1'b0, 0, 0, c0);
        check("R8 wrap tick suppressed", ticks - n0, 0);
        wait_tick(h * 2 + 20, t2);
        check("R8 restart after collision", t2 - c0, h + 2);
    endtask

    initial begin
        checks = 0; errors = 0;
        hp_wr = 1'b0; hp_value = '0; div_wr = 1'b0; div_value = '0;
        eng_busy = 1'b0; eng_hold = 1'b0;
        cur_thp = 24; cur_m = 2; cur_n = 0;
        @(negedge clk); #1;
        t_reset();
        t_default();
        t_rate(1'b1, 9, 1'b1, 3, 2, "R3 m3n2");
        t_rate(1'b1, 6, 1'b1, 1, 1, "R3 m1n1");
        t_rate(1'b1, 5, 1'b1, 5, 0, "R3 m5n0");
        t_rate(1'b1, 7, 1'b1, 0, 3, "R3 m0n3");
        t_rate(1'b1, 9, 1'b0, 0, 0, "R3 thp only");
        t_rate(1'b1, 2, 1'b1, 0, 0, "R4 clamp 2");
        t_rate(1'b1, 0, 1'b1, 1, 0, "R4 clamp 0");
        t_rate(1'b1, 5, 1'b1, 0, 0, "R2 fastest");
        t_hold();
        t_collide();
        check("R5 single-cycle ticks", wide, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule